// File: doc/BRIEF.md
# AXI Response Latency Shaper

This block sits on an AXI link between a master and a memory port and gives the master predictable memory timing. Each read or write request gets a deadline when it is accepted. The first read data beat, or the write response, is then held back from the master until that deadline has been reached. Reads and writes also count against programmable outstanding-transaction limits. When a limit is reached, the address handshake toward the master is stalled.

Held responses stay with the memory: the block lowers the ready signal on the memory side until the deadline is reached. A response whose deadline has already passed when the memory first presents it goes straight through, and a one-cycle underrun pulse marks the missed deadline. Configuration arrives as static inputs. One transaction ID is assumed, so responses return in order.

Top module: `lat_shaper`

## Requirements
- R1: The first beat of a read response reaches the master (up_r_valid high) no earlier than max(cfg_rd_lat, 1) cycles after the clock edge at which the read address was accepted. Until then dn_r_ready stays low.
- R2: A write response reaches the master (up_b_valid high) no earlier than max(cfg_wr_lat, 1) cycles after the clock edge at which the write beat with up_w_last was accepted.
- R3: A response the memory presents at or after its deadline is forwarded in that same cycle. Later beats of a read burst pass through with no added delay.
- R4: rd_underrun is high for exactly one cycle, the cycle after the memory first presents a first read beat whose deadline has already passed. A beat presented exactly at its deadline raises no pulse.
- R5: wr_underrun follows the same rule as R4 for write responses.
- R6: With cfg_rd_max nonzero, no read address is accepted while the number of reads accepted but not yet finished (last beat handed to the master) equals cfg_rd_max.
- R7: With cfg_wr_max nonzero, no write address is accepted while the number of writes accepted but not yet answered on B equals cfg_wr_max.
- R8: With cfg_rw_max nonzero, neither address channel accepts a request while reads plus writes outstanding equals cfg_rw_max. If one slot is left and both channels request in the same cycle, the read is accepted and the write is stalled.
- R9: A limit value of 0 means no limit from that setting. Each direction is still capped at DEPTH outstanding transactions.
- R10: While reset is held and after reset is released, with no requests pending, up_r_valid, up_b_valid, rd_underrun and wr_underrun are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_max | input | 6 | Read outstanding limit, 0 = none |
| cfg_wr_max | input | 6 | Write outstanding limit, 0 = none |
| cfg_rw_max | input | 6 | Combined outstanding limit, 0 = none |
| cfg_rd_lat | input | 12 | Minimum read latency in cycles |
| cfg_wr_lat | input | 12 | Minimum write-response latency in cycles |
| up_ar_valid | input | 1 | Read address valid from master |
| up_ar_ready | output | 1 | Read address ready to master |
| up_ar_addr | input | ADDR_W | Read address |
| up_ar_len | input | 8 | Read burst length |
| dn_ar_valid | output | 1 | Read address valid to memory |
| dn_ar_ready | input | 1 | Read address ready from memory |
| dn_ar_addr | output | ADDR_W | Read address to memory |
| dn_ar_len | output | 8 | Read burst length to memory |
| dn_r_valid | input | 1 | Read data valid from memory |
| dn_r_ready | output | 1 | Read data ready to memory |
| dn_r_data | input | DATA_W | Read data from memory |
| dn_r_last | input | 1 | Last read beat from memory |
| up_r_valid | output | 1 | Read data valid to master |
| up_r_ready | input | 1 | Read data ready from master |
| up_r_data | output | DATA_W | Read data to master |
| up_r_last | output | 1 | Last read beat to master |
| up_aw_valid | input | 1 | Write address valid from master |
| up_aw_ready | output | 1 | Write address ready to master |
| up_aw_addr | input | ADDR_W | Write address |
| up_aw_len | input | 8 | Write burst length |
| dn_aw_valid | output | 1 | Write address valid to memory |
| dn_aw_ready | input | 1 | Write address ready from memory |
| dn_aw_addr | output | ADDR_W | Write address to memory |
| dn_aw_len | output | 8 | Write burst length to memory |
| up_w_valid | input | 1 | Write data valid from master |
| up_w_ready | output | 1 | Write data ready to master |
| up_w_data | input | DATA_W | Write data |
| up_w_last | input | 1 | Last write beat |
| dn_w_valid | output | 1 | Write data valid to memory |
| dn_w_ready | input | 1 | Write data ready from memory |
| dn_w_data | output | DATA_W | Write data to memory |
| dn_w_last | output | 1 | Last write beat to memory |
| dn_b_valid | input | 1 | Write response valid from memory |
| dn_b_ready | output | 1 | Write response ready to memory |
| up_b_valid | output | 1 | Write response valid to master |
| up_b_ready | input | 1 | Write response ready from master |
| rd_underrun | output | 1 | One-cycle pulse: read deadline missed |
| wr_underrun | output | 1 | One-cycle pulse: write deadline missed |

## Verification
The bench builds the block with DEPTH = 4, ADDR_W = 16 and DATA_W = 32. The small depth means a handful of requests with all limits at zero is enough to reach the per-direction cap, so the meaning of "zero" in R9 can be seen at the ports. The latencies and memory delays in the vector table run from 0 to 12 cycles. They cover memory that answers early, exactly on the deadline, and late, so the held, on-time and underrun paths are all exercised.

// File: rtl/lat_shaper_pkg.sv
package lat_shaper_pkg;
  localparam int LIM_W = 6;
  localparam int LAT_W = 12;
  localparam int TS_W  = LAT_W + 2;

  typedef logic [TS_W-1:0] ts_t;

  // deadline reached: now - dl is non-negative in wrap-around arithmetic
  function automatic logic ts_reached(input ts_t now, input ts_t dl);
    ts_t diff;
    diff = now - dl;
    return ~diff[TS_W-1];
  endfunction

  // deadline strictly passed
  function automatic logic ts_passed(input ts_t now, input ts_t dl);
    ts_t diff;
    diff = now - dl;
    return ~diff[TS_W-1] & (diff != '0);
  endfunction
endpackage

// File: rtl/lat_ts_fifo.sv
module lat_ts_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wp_q, wp_d, rp_q, rp_d;
  logic         do_push, do_pop;

  always_comb begin
    empty_o = (wp_q == rp_q);
    full_o  = (wp_q[PW-1:0] == rp_q[PW-1:0]) && (wp_q[PW] != rp_q[PW]);
    do_push = push_i & ~full_o;
    do_pop  = pop_i & ~empty_o;
    wp_d    = do_push ? wp_q + 1'b1 : wp_q;
    rp_d    = do_pop  ? rp_q + 1'b1 : rp_q;
    head_o  = mem[rp_q[PW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q[PW-1:0]] <= din_i;
  end
endmodule

// File: rtl/lat_gate.sv
module lat_gate
  import lat_shaper_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  ts_t  now_i,
  input  logic push_i,
  input  ts_t  push_ts_i,
  output logic full_o,
  input  logic s_valid_i,
  input  logic s_last_i,
  output logic s_ready_o,
  output logic m_valid_o,
  input  logic m_ready_i,
  output logic underrun_o
);
  ts_t  head;
  logic empty, open, hs, pop, look, late;
  logic burst_q, burst_d, seen_q, seen_d, unr_q, unr_d;

  lat_ts_fifo #(.DEPTH(DEPTH), .W(TS_W)) u_q (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (push_i),
    .din_i  (push_ts_i),
    .pop_i  (pop),
    .head_o (head),
    .empty_o(empty),
    .full_o (full_o)
  );

  always_comb begin
    open      = burst_q | (~empty & ts_reached(now_i, head));
    late      = ~empty & ts_passed(now_i, head);
    m_valid_o = s_valid_i & open;
    s_ready_o = m_ready_i & open;
    hs        = s_valid_i & m_ready_i & open;
    pop       = hs & ~burst_q;
    burst_d   = hs ? ~s_last_i : burst_q;
    look      = s_valid_i & ~burst_q & ~empty & ~seen_q;
    seen_d    = pop ? 1'b0 : (look ? 1'b1 : seen_q);
    unr_d     = look & late;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      seen_q  <= 1'b0;
      unr_q   <= 1'b0;
    end else begin
      burst_q <= burst_d;
      seen_q  <= seen_d;
      unr_q   <= unr_d;
    end
  end

  assign underrun_o = unr_q;
endmodule

// File: rtl/pend_limit.sv
module pend_limit
  import lat_shaper_pkg::*;
#(
  parameter int CAP = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] rd_max_i,
  input  logic [LIM_W-1:0] wr_max_i,
  input  logic [LIM_W-1:0] rw_max_i,
  input  logic             rd_req_i,
  input  logic             rd_inc_i,
  input  logic             rd_dec_i,
  input  logic             wr_inc_i,
  input  logic             wr_dec_i,
  output logic             rd_block_o,
  output logic             wr_block_o
);
  localparam int CW = $clog2(CAP + 1);
  localparam int XW = ((CW + 1) > (LIM_W + 1)) ? (CW + 1) : (LIM_W + 1);

  logic [CW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [XW-1:0] rd_x, wr_x, sum_x, cap_x, rdm_x, wrm_x, rwm_x;
  logic          rd_go;

  always_comb begin
    rd_x  = XW'(rd_q);
    wr_x  = XW'(wr_q);
    sum_x = rd_x + wr_x;
    cap_x = XW'(CAP);
    rdm_x = XW'(rd_max_i);
    wrm_x = XW'(wr_max_i);
    rwm_x = XW'(rw_max_i);

    rd_block_o = (rd_x >= cap_x)
               | ((rd_max_i != '0) & (rd_x >= rdm_x))
               | ((rw_max_i != '0) & (sum_x >= rwm_x));
    rd_go      = rd_req_i & ~rd_block_o;
    // a read claiming the last combined slot wins over a write
    wr_block_o = (wr_x >= cap_x)
               | ((wr_max_i != '0) & (wr_x >= wrm_x))
               | ((rw_max_i != '0) & ((sum_x + XW'(rd_go)) >= rwm_x));

    unique case ({rd_inc_i, rd_dec_i})
      2'b10:   rd_d = rd_q + 1'b1;
      2'b01:   rd_d = rd_q - 1'b1;
      default: rd_d = rd_q;
    endcase
    unique case ({wr_inc_i, wr_dec_i})
      2'b10:   wr_d = wr_q + 1'b1;
      2'b01:   wr_d = wr_q - 1'b1;
      default: wr_d = wr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      rd_q <= rd_d;
      wr_q <= wr_d;
    end
  end
endmodule

// File: rtl/lat_shaper.sv
module lat_shaper
  import lat_shaper_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        cfg_rd_max,
  input  logic [5:0]        cfg_wr_max,
  input  logic [5:0]        cfg_rw_max,
  input  logic [11:0]       cfg_rd_lat,
  input  logic [11:0]       cfg_wr_lat,
  input  logic              up_ar_valid,
  output logic              up_ar_ready,
  input  logic [ADDR_W-1:0] up_ar_addr,
  input  logic [7:0]        up_ar_len,
  output logic              dn_ar_valid,
  input  logic              dn_ar_ready,
  output logic [ADDR_W-1:0] dn_ar_addr,
  output logic [7:0]        dn_ar_len,
  input  logic              dn_r_valid,
  output logic              dn_r_ready,
  input  logic [DATA_W-1:0] dn_r_data,
  input  logic              dn_r_last,
  output logic              up_r_valid,
  input  logic              up_r_ready,
  output logic [DATA_W-1:0] up_r_data,
  output logic              up_r_last,
  input  logic              up_aw_valid,
  output logic              up_aw_ready,
  input  logic [ADDR_W-1:0] up_aw_addr,
  input  logic [7:0]        up_aw_len,
  output logic              dn_aw_valid,
  input  logic              dn_aw_ready,
  output logic [ADDR_W-1:0] dn_aw_addr,
  output logic [7:0]        dn_aw_len,
  input  logic              up_w_valid,
  output logic              up_w_ready,
  input  logic [DATA_W-1:0] up_w_data,
  input  logic              up_w_last,
  output logic              dn_w_valid,
  input  logic              dn_w_ready,
  output logic [DATA_W-1:0] dn_w_data,
  output logic              dn_w_last,
  input  logic              dn_b_valid,
  output logic              dn_b_ready,
  output logic              up_b_valid,
  input  logic              up_b_ready,
  output logic              rd_underrun,
  output logic              wr_underrun
);
  ts_t  now_q, now_d, rd_ts, wr_ts;
  logic rd_block, wr_block, rq_full, wq_full;
  logic ar_stall, aw_stall, ar_hs, aw_hs, wl_hs, rl_hs, b_hs;

  always_comb begin
    now_d = now_q + 1'b1;
    rd_ts = now_q + TS_W'(cfg_rd_lat);
    wr_ts = now_q + TS_W'(cfg_wr_lat);

    ar_stall    = rd_block | rq_full;
    aw_stall    = wr_block;
    dn_ar_valid = up_ar_valid & ~ar_stall;
    up_ar_ready = dn_ar_ready & ~ar_stall;
    dn_aw_valid = up_aw_valid & ~aw_stall;
    up_aw_ready = dn_aw_ready & ~aw_stall;
    dn_w_valid  = up_w_valid & ~wq_full;
    up_w_ready  = dn_w_ready & ~wq_full;

    dn_ar_addr = up_ar_addr;
    dn_ar_len  = up_ar_len;
    dn_aw_addr = up_aw_addr;
    dn_aw_len  = up_aw_len;
    dn_w_data  = up_w_data;
    dn_w_last  = up_w_last;
    up_r_data  = dn_r_data;
    up_r_last  = dn_r_last;

    ar_hs = up_ar_valid & up_ar_ready;
    aw_hs = up_aw_valid & up_aw_ready;
    wl_hs = up_w_valid & up_w_ready & up_w_last;
    rl_hs = up_r_valid & up_r_ready & dn_r_last;
    b_hs  = up_b_valid & up_b_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_d;
  end

  pend_limit #(.CAP(DEPTH)) u_limit (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_max_i  (cfg_rd_max),
    .wr_max_i  (cfg_wr_max),
    .rw_max_i  (cfg_rw_max),
    .rd_req_i  (up_ar_valid & dn_ar_ready),
    .rd_inc_i  (ar_hs),
    .rd_dec_i  (rl_hs),
    .wr_inc_i  (aw_hs),
    .wr_dec_i  (b_hs),
    .rd_block_o(rd_block),
    .wr_block_o(wr_block)
  );

  lat_gate #(.DEPTH(DEPTH)) u_rd_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .now_i     (now_q),
    .push_i    (ar_hs),
    .push_ts_i (rd_ts),
    .full_o    (rq_full),
    .s_valid_i (dn_r_valid),
    .s_last_i  (dn_r_last),
    .s_ready_o (dn_r_ready),
    .m_valid_o (up_r_valid),
    .m_ready_i (up_r_ready),
    .underrun_o(rd_underrun)
  );

  lat_gate #(.DEPTH(DEPTH)) u_wr_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .now_i     (now_q),
    .push_i    (wl_hs),
    .push_ts_i (wr_ts),
    .full_o    (wq_full),
    .s_valid_i (dn_b_valid),
    .s_last_i  (1'b1),
    .s_ready_o (dn_b_ready),
    .m_valid_o (up_b_valid),
    .m_ready_i (up_b_ready),
    .underrun_o(wr_underrun)
  );
endmodule

// File: rtl/lat_shaper_chk.sv
module lat_shaper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] cfg_rd_max,
  input logic [5:0] cfg_wr_max,
  input logic [5:0] cfg_rw_max,
  input logic       up_ar_valid,
  input logic       up_ar_ready,
  input logic       up_aw_valid,
  input logic       up_aw_ready,
  input logic       dn_r_valid,
  input logic       dn_r_ready,
  input logic       dn_r_last,
  input logic       up_r_valid,
  input logic       up_r_ready,
  input logic       dn_b_valid,
  input logic       dn_b_ready,
  input logic       up_b_valid,
  input logic       up_b_ready,
  input logic       rd_underrun,
  input logic       wr_underrun
);
  logic [7:0] rd_out, wr_out;
  logic [8:0] sum_out;
  logic       ar_hs, aw_hs, rl_hs, b_hs;

  always_comb begin
    ar_hs   = up_ar_valid & up_ar_ready;
    aw_hs   = up_aw_valid & up_aw_ready;
    rl_hs   = up_r_valid & up_r_ready & dn_r_last;
    b_hs    = up_b_valid & up_b_ready;
    sum_out = {1'b0, rd_out} + {1'b0, wr_out};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_out <= '0;
      wr_out <= '0;
    end else begin
      rd_out <= rd_out + {7'd0, ar_hs} - {7'd0, rl_hs};
      wr_out <= wr_out + {7'd0, aw_hs} - {7'd0, b_hs};
    end
  end

  // R1
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_r_valid |-> dn_r_valid);
  // R3
  r_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_r_valid && dn_r_ready) |-> (up_r_valid && up_r_ready));
  // R2
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_b_valid && dn_b_ready) |-> (up_b_valid && up_b_ready));
  // R4
  rd_unr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_underrun) |-> $past(dn_r_valid));
  // R5
  wr_unr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_underrun) |-> $past(dn_b_valid));
  // R6
  rd_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_rd_max != 6'd0) && (rd_out >= {2'b00, cfg_rd_max})) |-> !ar_hs);
  // R7
  wr_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_wr_max != 6'd0) && (wr_out >= {2'b00, cfg_wr_max})) |-> !aw_hs);
  // R8
  rw_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_rw_max != 6'd0) && (sum_out >= {3'b000, cfg_rw_max})) |-> (!ar_hs && !aw_hs));
endmodule

bind lat_shaper lat_shaper_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_rd_max (cfg_rd_max),
  .cfg_wr_max (cfg_wr_max),
  .cfg_rw_max (cfg_rw_max),
  .up_ar_valid(up_ar_valid),
  .up_ar_ready(up_ar_ready),
  .up_aw_valid(up_aw_valid),
  .up_aw_ready(up_aw_ready),
  .dn_r_valid (dn_r_valid),
  .dn_r_ready (dn_r_ready),
  .dn_r_last  (dn_r_last),
  .up_r_valid (up_r_valid),
  .up_r_ready (up_r_ready),
  .dn_b_valid (dn_b_valid),
  .dn_b_ready (dn_b_ready),
  .up_b_valid (up_b_valid),
  .up_b_ready (up_b_ready),
  .rd_underrun(rd_underrun),
  .wr_underrun(wr_underrun)
);

// File: tb/test_lat_shaper.sv
module test_lat_shaper;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic       wr;    // 0 = read channel, 1 = write channel
    logic [11:0] lat;
    logic [7:0] dly;   // memory answers in cycle dly after the request edge
    logic [7:0] exp_k; // cycle in which the master sees valid
    logic       unr;   // underrun pulse expected in cycle dly+1
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'd5,  8'd2, 8'd5,  1'b0},
    '{1'b0, 12'd3,  8'd7, 8'd7,  1'b1},
    '{1'b0, 12'd4,  8'd4, 8'd4,  1'b0},
    '{1'b0, 12'd0,  8'd1, 8'd1,  1'b1},
    '{1'b0, 12'd1,  8'd1, 8'd1,  1'b0},
    '{1'b0, 12'd12, 8'd3, 8'd12, 1'b0},
    '{1'b1, 12'd6,  8'd2, 8'd6,  1'b0},
    '{1'b1, 12'd2,  8'd9, 8'd9,  1'b1},
    '{1'b1, 12'd3,  8'd3, 8'd3,  1'b0},
    '{1'b1, 12'd0,  8'd2, 8'd2,  1'b1}
  };

  logic clk, rst_n;
  logic [5:0] cfg_rd_max, cfg_wr_max, cfg_rw_max;
  logic [11:0] cfg_rd_lat, cfg_wr_lat;
  logic up_ar_valid, up_ar_ready, dn_ar_valid, dn_ar_ready;
  logic [ADDR_W-1:0] up_ar_addr, dn_ar_addr, up_aw_addr, dn_aw_addr;
  logic [7:0] up_ar_len, dn_ar_len, up_aw_len, dn_aw_len;
  logic dn_r_valid, dn_r_ready, dn_r_last, up_r_valid, up_r_ready, up_r_last;
  logic [DATA_W-1:0] dn_r_data, up_r_data, up_w_data, dn_w_data;
  logic up_aw_valid, up_aw_ready, dn_aw_valid, dn_aw_ready;
  logic up_w_valid, up_w_ready, up_w_last, dn_w_valid, dn_w_ready, dn_w_last;
  logic dn_b_valid, dn_b_ready, up_b_valid, up_b_ready;
  logic rd_underrun, wr_underrun;

  int checks = 0;
  int errors = 0;

  lat_shaper #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_lat_shaper (.*);

  initial clk = 1'b0;
  always #2.5ns clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    up_ar_valid = 0; up_aw_valid = 0; up_w_valid = 0; up_w_last = 0;
    dn_r_valid = 0; dn_r_last = 0; dn_b_valid = 0;
    dn_ar_ready = 1; dn_aw_ready = 1; dn_w_ready = 1;
    up_r_ready = 1; up_b_ready = 1;
    up_ar_addr = '0; up_ar_len = '0; up_aw_addr = '0; up_aw_len = '0;
    up_w_data = '0; dn_r_data = '0;
    cfg_rd_max = 0; cfg_wr_max = 0; cfg_rw_max = 0;
    cfg_rd_lat = 0; cfg_wr_lat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // hold request valids for n cycles, counting accepted handshakes
  task automatic hold_req(input bit rd, input bit wr, input int n,
                          output int nr, output int nw);
    nr = 0; nw = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      up_ar_valid = rd; up_aw_valid = wr;
      #1ns;
      if (rd && up_ar_ready) nr++;
      if (wr && up_aw_ready) nw++;
    end
    @(negedge clk);
    up_ar_valid = 0; up_aw_valid = 0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int first_k = -1;
    int unr_k   = -1;
    bit done    = 0;
    string tag;
    tag = v.wr ? "R2/R5" : "R1/R4";
    cfg_rd_lat = v.lat; cfg_wr_lat = v.lat;
    @(negedge clk);
    if (v.wr) begin
      up_aw_valid = 1; up_w_valid = 1; up_w_last = 1;
    end else begin
      up_ar_valid = 1;
    end
    @(posedge clk);
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      up_ar_valid = 0; up_aw_valid = 0; up_w_valid = 0; up_w_last = 0;
      if (v.wr) dn_b_valid = (k >= int'(v.dly)) && !done;
      else begin
        dn_r_valid = (k >= int'(v.dly)) && !done;
        dn_r_last  = 1'b1;
      end
      #1ns;
      if ((v.wr ? up_b_valid : up_r_valid) && first_k < 0) begin
        first_k = k; done = 1;
      end
      if ((v.wr ? wr_underrun : rd_underrun) && unr_k < 0) unr_k = k;
    end
    dn_r_valid = 0; dn_b_valid = 0; dn_r_last = 0;
    $display("vector %0d", idx);
    check({tag, " latency"}, first_k, int'(v.exp_k));
    check({tag, " underrun cycle"}, unr_k, v.unr ? int'(v.dly) + 1 : -1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    int nr, nw;
    int bt [3];
    int beat;
    do_reset();
    // R10 reset state
    check("R10 up_r_valid", up_r_valid, 0);
    check("R10 up_b_valid", up_b_valid, 0);
    check("R10 rd_underrun", rd_underrun, 0);
    check("R10 wr_underrun", wr_underrun, 0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      run_vec(VECS[i], i);
    end

    // R3 burst: first beat held to deadline, later beats not delayed
    do_reset();
    cfg_rd_lat = 2;
    @(negedge clk); up_ar_valid = 1; up_ar_len = 8'd2;
    @(posedge clk);
    beat = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      up_ar_valid = 0;
      dn_r_valid = (beat < 3);
      dn_r_last  = (beat == 2);
      #1ns;
      if (up_r_valid && up_r_ready && beat < 3) begin
        bt[beat] = k; beat++;
      end
    end
    dn_r_valid = 0; dn_r_last = 0;
    check("R3 beat0", bt[0], 2);
    check("R3 beat1", bt[1], 3);
    check("R3 beat2", bt[2], 4);

    // R6 read limit
    do_reset();
    cfg_rd_max = 2;
    hold_req(1, 0, 4, nr, nw);
    check("R6 reads accepted", nr, 2);
    @(negedge clk); up_ar_valid = 1; #1ns;
    check("R6 stalled ready", up_ar_ready, 0);
    dn_r_valid = 1; dn_r_last = 1; up_ar_valid = 0;
    @(negedge clk); dn_r_valid = 0; dn_r_last = 0; up_ar_valid = 1; #1ns;
    check("R6 ready after completion", up_ar_ready, 1);
    up_ar_valid = 0;

    // R7 write limit
    do_reset();
    cfg_wr_max = 1;
    hold_req(0, 1, 3, nr, nw);
    check("R7 writes accepted", nw, 1);

    // R8 combined limit, read wins the last slot
    do_reset();
    cfg_rw_max = 1;
    @(negedge clk); up_ar_valid = 1; up_aw_valid = 1; #1ns;
    check("R8 read wins", up_ar_ready, 1);
    check("R8 write stalled", up_aw_ready, 0);
    @(negedge clk); #1ns;
    check("R8 read full", up_ar_ready, 0);
    check("R8 write full", up_aw_ready, 0);
    up_ar_valid = 0; up_aw_valid = 0;

    // R9 zero limits: cap at DEPTH
    do_reset();
    hold_req(1, 1, 6, nr, nw);
    check("R9 reads up to depth", nr, DEPTH);
    check("R9 writes up to depth", nw, DEPTH);

    report();
  end
endmodule